// File: doc/BRIEF.md
# Carrier-Keyed Infrared Serial Codec

This block sends and receives bytes over an infrared link in which each bit period is either filled with a square-wave carrier or left dark. A dark period means a one and a carrier burst means a zero. On the transmit side a byte is taken through a valid/ready handshake. It is framed as an asynchronous character: a start bit of value zero, eight data bits with the least significant bit first, and one stop bit of value one. The carrier that is gated onto the emitter output is divided down from the system clock. It has a 50% duty cycle and its phase restarts, high, at the start of every zero bit.

The receive side takes the detector output. The first rising edge it sees while idle marks the start of a frame. From that edge it counts rising edges inside consecutive windows, each one bit period long. A window whose edge count is above a programmable threshold decodes as zero. The bit period, the carrier half period and the edge threshold are run-time inputs. The same block serves rates up to about 19.2 kbit/s with a carrier near 500 kHz, or any other ratio the dividers allow.

Top module: `ask_ir_codec`

## Requirements
- R1: While rst_ni is low, ir_tx_o is 0, tx_ready_o is 1 and rx_valid_o is 0.
- R2: A byte is taken in a cycle where tx_valid_i and tx_ready_o are both 1. tx_ready_o then stays 0 for the whole frame, which lasts 10 × bit_div_i cycles.
- R3: The transmitted frame is 10 bit periods of bit_div_i cycles each, in this order: the start bit (0), data bit 0 through data bit 7, then the stop bit (1).
- R4: During a zero bit, ir_tx_o carries a square wave with period 2 × car_half_i cycles and a 50% duty cycle. The wave is high in the first cycle of each zero bit, including the cycle right after the byte is taken.
- R5: ir_tx_o stays 0 during one bits and whenever the transmitter is idle (tx_ready_o = 1).
- R6: While the receiver is idle, the first rising edge on ir_rx_i opens a frame. Each bit window lasts bit_div_i cycles, and that first edge counts toward the start window.
- R7: A window decodes as 0 when its rising-edge count is greater than edge_thr_i, and as 1 otherwise. The eight windows after the start window are assembled LSB first onto rx_data_o.
- R8: If the start window decodes as 1, the frame is dropped, no byte is delivered, and the receiver goes back to idle.
- R9: rx_valid_o pulses high for exactly one cycle after the last data window of each accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_div_i | input | CNT_W | Clock cycles per bit period |
| car_half_i | input | CNT_W | Clock cycles per carrier half period |
| edge_thr_i | input | CNT_W | Rising-edge count that a window must exceed to read as zero |
| tx_valid_i | input | 1 | Byte offered for transmission |
| tx_data_i | input | DATA_W | Byte to transmit |
| tx_ready_o | output | 1 | Transmitter idle and able to take a byte |
| ir_tx_o | output | 1 | Gated carrier to the emitter |
| ir_rx_i | input | 1 | Detector output, asynchronous |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |

## Verification
The bench builds the block with the default parameters: CNT_W of 16 and DATA_W of 8. It changes the divider inputs at run time. A 40-cycle bit with a 4-cycle carrier gives ten pulses per zero bit, and a 24-cycle bit with a 6-cycle carrier gives four. Both settings are sent back through the receiver over a loopback. A threshold set above the possible pulse count checks that start bits are rejected, and a lone short pulse on the detector input checks that a false start is dropped.

// File: rtl/ask_ir_pkg.sv
package ask_ir_pkg;
  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_e;
  localparam int unsigned FRAME_EXTRA = 2; // start + stop
endpackage

// File: rtl/ask_ir_carrier.sv
module ask_ir_carrier #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             lvl_o
);
  localparam logic [CNT_W-1:0] ONE = 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      lvl_o <= 1'b1;
    end else if (cnt_q >= half_i - ONE) begin
      cnt_q <= '0;
      lvl_o <= ~lvl_o;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/ask_ir_tx.sv
module ask_ir_tx #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  bit_div_i,
  input  logic [CNT_W-1:0]  car_half_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              ir_o
);
  localparam int unsigned FRAME_W = DATA_W + ask_ir_pkg::FRAME_EXTRA;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic               busy_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               accept, bit_end, last_bit, restart, car_lvl;

  assign accept   = valid_i & ~busy_q;
  assign bit_end  = busy_q && (cnt_q >= bit_div_i - ONE);
  assign last_bit = (idx_q == LAST_IDX);
  assign restart  = accept | (bit_end & ~last_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      frame_q <= {1'b1, data_i, 1'b0};
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (bit_end) begin
      cnt_q <= '0;
      if (last_bit) begin
        busy_q <= 1'b0;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        idx_q   <= idx_q + 1'b1;
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  ask_ir_carrier #(.CNT_W(CNT_W)) u_car (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .half_i    (car_half_i),
    .lvl_o     (car_lvl)
  );

  assign ready_o = ~busy_q;
  assign ir_o    = busy_q & ~frame_q[0] & car_lvl;
endmodule

// File: rtl/ask_ir_rx.sv
module ask_ir_rx #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  bit_div_i,
  input  logic [CNT_W-1:0]  thr_i,
  input  logic              ir_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  import ask_ir_pkg::*;
  localparam int unsigned IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);

  logic [1:0]        sync_q;
  logic              prev_q, rise;
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, edges_q, total;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              win_end, is_zero;

  assign rise    = sync_q[1] & ~prev_q;
  assign win_end = (state_q == RX_BUSY) && (cnt_q >= bit_div_i - ONE);
  assign total   = edges_q + {{(CNT_W-1){1'b0}}, rise};
  assign is_zero = total > thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ir_i};
      prev_q <= sync_q[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      edges_q <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (state_q == RX_IDLE) begin
        if (rise) begin
          state_q <= RX_BUSY;
          cnt_q   <= ONE;
          edges_q <= ONE;
          idx_q   <= '0;
        end
      end else if (win_end) begin
        cnt_q   <= '0;
        edges_q <= '0;
        if (idx_q == '0) begin
          if (!is_zero) state_q <= RX_IDLE;   // false start
          else          idx_q   <= idx_q + 1'b1;
        end else begin
          sh_q <= {~is_zero, sh_q[DATA_W-1:1]};
          if (idx_q == LAST_IDX) begin
            state_q <= RX_IDLE;
            valid_o <= 1'b1;
            data_o  <= {~is_zero, sh_q[DATA_W-1:1]};
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end else begin
        cnt_q   <= cnt_q + ONE;
        edges_q <= total;
      end
    end
  end
endmodule

// File: rtl/ask_ir_codec.sv
module ask_ir_codec #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  bit_div_i,
  input  logic [CNT_W-1:0]  car_half_i,
  input  logic [CNT_W-1:0]  edge_thr_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              ir_tx_o,
  input  logic              ir_rx_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  ask_ir_tx #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_div_i  (bit_div_i),
    .car_half_i (car_half_i),
    .valid_i    (tx_valid_i),
    .data_i     (tx_data_i),
    .ready_o    (tx_ready_o),
    .ir_o       (ir_tx_o)
  );

  ask_ir_rx #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_div_i (bit_div_i),
    .thr_i     (edge_thr_i),
    .ir_i      (ir_rx_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o)
  );
endmodule

// File: rtl/ask_ir_checker.sv
module ask_ir_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic ir_tx_o,
  input logic rx_valid_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r1: assert (tx_ready_o && !ir_tx_o && !rx_valid_o)
        else $error("reset state wrong");
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  p_start_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> ir_tx_o);

  p_idle_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !ir_tx_o);

  p_strobe_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind ask_ir_codec ask_ir_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .ir_tx_o    (ir_tx_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/ask_ir_codec_tb.sv
module ask_ir_codec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] bit_div = 16'd40, car_half = 16'd2, thr = 16'd4;
  logic tx_valid = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic tx_ready, ir_tx, rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic loop_sel = 1'b1, force_rx = 1'b0, ir_rx;

  int checks = 0, fails = 0, rx_count = 0;
  logic [DATA_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ir_rx = loop_sel ? ir_tx : force_rx;

  ask_ir_codec #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_div_i(bit_div), .car_half_i(car_half),
    .edge_thr_i(thr), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .ir_tx_o(ir_tx), .ir_rx_i(ir_rx),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: R7 R9 scoreboard
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_count++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected rx byte", rx_data, -1);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R7 rx byte", rx_data, e);
      end
    end
  end

  // driver: sends one byte, checks each bit period of ir_tx (R2 R3 R4 R5)
  task automatic send(input logic [DATA_W-1:0] b, input bit expect_rx);
    logic [9:0] frame;
    int pulses, highs, first_run;
    logic prev;
    frame = {1'b1, b, 1'b0};
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    if (expect_rx) exp_q.push_back(b);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int k = 0; k < 10; k++) begin
      pulses = 0; highs = 0; first_run = 0; prev = 1'b0;
      for (int c = 0; c < int'(bit_div); c++) begin
        if (c > 0) @(negedge clk);
        if (ir_tx && !prev) pulses++;
        if (ir_tx) highs++;
        if (ir_tx && pulses == 1) first_run++;
        if (k == 4 && c == 0) check(tx_ready == 1'b0, "R2 ready low mid-frame", tx_ready, 0);
        prev = ir_tx;
      end
      if (frame[k]) begin
        check(pulses == 0 && highs == 0, "R5 one bit dark", highs, 0);
      end else begin
        check(pulses == int'(bit_div) / (2 * int'(car_half)), "R3 zero bit pulses",
              pulses, int'(bit_div) / (2 * int'(car_half)));
        check(highs == int'(bit_div) / 2, "R4 duty", highs, int'(bit_div) / 2);
        check(first_run == int'(car_half), "R4 first high run", first_run, int'(car_half));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ir_tx == 1'b0 && tx_ready == 1'b1 && rx_valid == 1'b0, "R1 reset state",
          {ir_tx, tx_ready, rx_valid}, 3'b010);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ir_tx == 1'b0, "R5 idle dark", ir_tx, 0);

    // R6 R7 loopback, 10 pulses per zero bit
    send(8'hA5, 1); send(8'h00, 1); send(8'hFF, 1); send(8'h01, 1); send(8'h80, 1);
    repeat (3 * 40) @(negedge clk);
    check(exp_q.size() == 0, "R7 all bytes received", exp_q.size(), 0);
    check(rx_count == 5, "R9 one strobe per byte", rx_count, 5);

    // R8 threshold above pulse count: start rejected
    thr = 16'd12;
    send(8'h3C, 0);
    repeat (4 * 40) @(negedge clk);
    check(rx_count == 5, "R8 start rejected by threshold", rx_count, 5);
    thr = 16'd4;

    // R8 lone glitch on detector input
    loop_sel = 1'b0;
    @(negedge clk); force_rx = 1'b1;
    repeat (2) @(negedge clk); force_rx = 1'b0;
    repeat (12 * 40) @(negedge clk);
    check(rx_count == 5, "R8 glitch dropped", rx_count, 5);
    loop_sel = 1'b1;
    send(8'h5A, 1);
    repeat (3 * 40) @(negedge clk);
    check(rx_count == 6, "R6 rx recovers after false start", rx_count, 6);

    // second divider setting: 4 pulses per zero bit
    bit_div = 16'd24; car_half = 16'd3; thr = 16'd2;
    send(8'hC3, 1); send(8'h7E, 1);
    repeat (3 * 24) @(negedge clk);
    check(exp_q.size() == 0 && rx_count == 8, "R7 second setting received", rx_count, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule